// File: doc/BRIEF.md
# Photovoltaic Diode Voltage Solver

This block solves the single-diode photovoltaic cell equation for the diode voltage at a given panel current and irradiance. It then turns that voltage into a panel terminal voltage. All quantities are signed fixed point, 48 bits wide with 24 fractional bits. The block runs Newton-Raphson steps, and every step needs two quantities:

- the exponent ratio V/Vt, from a shared restoring divider;
- e^(V/Vt), from a shared exponential unit that works by Horner evaluation of a Taylor polynomial on V/(32·Vt) followed by five squarings.

The first estimate comes from a quadratic in irradiance. With it, a cell whose operating point is near that curve settles in a handful of steps.

A one-cycle start pulse captures every input while the block is idle. Busy stays high for the whole solve. The block stops when the magnitude of a step falls below a programmable tolerance, or after a fixed number of steps, in which case a cap flag is raised. A last stage adds linear temperature corrections to the panel voltage and to the panel current. A one-cycle done pulse then presents the results, and they stay held until the next solve finishes.

Top module: `pv_nr_solver`

## Requirements
- R1: After reset, busy_o, done_o, cap_hit_o, iter_o, vdiode_o, vpanel_o and icorr_o are all zero.
- R2: A start pulse is taken only while busy_o is low. A start during a solve changes neither that solve's result nor busy_o.
- R3: busy_o is high from the cycle after an accepted start until the done pulse. done_o lasts exactly one cycle and coincides with busy_o low. Results do not change while the block is idle.
- R4: The first estimate is 0.5 + s − 2.25·s², with s = 0.1·SR/1000. If the tolerance exceeds the first step, the block stops after one step with vdiode_o equal to that estimate minus one Newton step.
- R5: Each step replaces V by V − Vt·(Ipv·Rp − G·SR·Rp + I0·Rp·e^(V/Vt) − I0·Rp + V)/(I0·Rp·e^(V/Vt) + Vt). The final vdiode_o agrees with the real-valued root within 1 mV.
- R6: Consider a cell whose root lies within about 0.05 V of the first estimate, at irradiances from 400 to 1000 W/m² and with a tolerance of 0.1 mV. Such a cell converges in 1 to 5 steps.
- R7: The solve ends at the first step whose magnitude is below tol_i. Otherwise it ends at step MAX_ITER (16), with cap_hit_o = 1 and iter_o = 16. A tolerance of zero always reaches the cap.
- R8: vpanel_o = N·(VD − Rs·Ipv) + CTv·(Tc − 25), where N is the unsigned integer ncell_i and Tc is in °C.
- R9: icorr_o = Ipv + CTi·(Tc − 25).
- R10: A start given in the cycle of a done pulse is accepted: busy_o is high in the next cycle, and the new solve uses the new inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, captures all inputs when idle |
| irr_i | input | 48 | Irradiance in W/m², fixed point |
| ipv_i | input | 48 | Panel current in A |
| gain_i | input | 48 | Photocurrent per W/m² |
| isat_i | input | 48 | Diode saturation current in A |
| rpar_i | input | 48 | Parallel resistance in Ω |
| rser_i | input | 48 | Series resistance in Ω |
| vt_i | input | 48 | Thermal voltage in V |
| ncell_i | input | 8 | Number of series cells |
| tol_i | input | 48 | Stop threshold on step magnitude in V |
| tcell_i | input | 48 | Cell temperature in °C |
| cti_i | input | 48 | Current temperature coefficient in A/°C |
| ctv_i | input | 48 | Voltage temperature coefficient in V/°C |
| busy_o | output | 1 | Solve in progress |
| done_o | output | 1 | One-cycle result strobe |
| vdiode_o | output | 48 | Final diode voltage |
| vpanel_o | output | 48 | Corrected panel voltage |
| icorr_o | output | 48 | Corrected panel current |
| iter_o | output | 5 | Number of Newton steps taken |
| cap_hit_o | output | 1 | Solve ended on the step cap |

## Verification
Two events can land in the same cycle:

- the done pulse of one solve;
- the start pulse of the next solve.

The bench waits for done_o, reads the finished results, and in that same cycle drives a start with a different irradiance and current. The overlap is judged correct if three things hold:

- busy_o rises in the next cycle;
- the earlier results were intact when done_o was seen;
- the second solve converges to the root of its own inputs rather than the first solve's inputs.

A start inside a running solve is also driven, to show that only the done cycle reopens the input capture.

// File: rtl/pv_nr_pkg.sv
// Shared definitions for the photovoltaic Newton-Raphson solver.
// Assumes: a single default fixed-point format used by all sub-units.
package pv_nr_pkg;
    localparam int FX_W    = 48;  // total fixed-point width
    localparam int FX_FRAC = 24;  // fractional bits

    typedef enum logic [3:0] {
        S_IDLE, S_PREP, S_XDIV, S_XWAIT, S_EXPS, S_EWAIT, S_QDIV, S_QWAIT, S_FIN
    } solve_st_e;

    typedef enum logic [1:0] {
        E_IDLE, E_HORN, E_SQR
    } exp_st_e;
endpackage

// File: rtl/pv_fx_div.sv
// Signed fixed-point restoring divider: quot = num / den with FRAC_W
// fractional bits. One quotient bit per cycle, DATA_W+FRAC_W cycles.
// Assumes: start only while idle; a zero divisor or a quotient too large
// for DATA_W saturates to the largest magnitude with the result sign.
module pv_fx_div #(
    parameter int DATA_W = pv_nr_pkg::FX_W,
    parameter int FRAC_W = pv_nr_pkg::FX_FRAC
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic signed [DATA_W-1:0] num_i,
    input  logic signed [DATA_W-1:0] den_i,
    output logic                     done_o,
    output logic signed [DATA_W-1:0] quot_o
);
    localparam int NW    = DATA_W + FRAC_W;
    localparam int CNT_W = $clog2(NW + 1);

    logic [NW-1:0]     dvd_q, quo_q;
    logic [DATA_W-1:0] dvs_q, rem_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              neg_q, run_q, done_q;
    logic signed [DATA_W-1:0] res_q;

    logic [DATA_W-1:0] num_mag, den_mag, rem_nx, mag_w;
    logic [DATA_W:0]   rem_sh;
    logic              fits;
    logic [NW-1:0]     quo_nx;

    // Magnitudes of the operands and one restoring step.
    always_comb begin
        num_mag = num_i[DATA_W-1] ? (~num_i + 1'b1) : num_i;
        den_mag = den_i[DATA_W-1] ? (~den_i + 1'b1) : den_i;
        rem_sh  = {rem_q, dvd_q[NW-1]};
        fits    = rem_sh >= {1'b0, dvs_q};
        rem_nx  = fits ? DATA_W'(rem_sh - {1'b0, dvs_q}) : rem_sh[DATA_W-1:0];
        quo_nx  = {quo_q[NW-2:0], fits};
        mag_w   = (|quo_nx[NW-1:DATA_W-1]) ? {1'b0, {(DATA_W-1){1'b1}}}
                                           : quo_nx[DATA_W-1:0];
    end

    // Division sequencer: load, shift/subtract, then publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            rem_q  <= '0;
            cnt_q  <= '0;
            neg_q  <= 1'b0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
            res_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (start_i && !run_q) begin
                dvd_q <= {num_mag, {FRAC_W{1'b0}}};
                dvs_q <= den_mag;
                rem_q <= '0;
                quo_q <= '0;
                cnt_q <= CNT_W'(NW);
                neg_q <= num_i[DATA_W-1] ^ den_i[DATA_W-1];
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= rem_nx;
                quo_q <= quo_nx;
                dvd_q <= dvd_q << 1;
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                    res_q  <= neg_q ? -$signed(mag_w) : $signed(mag_w);
                end
            end
        end
    end

    assign done_o = done_q;
    assign quot_o = res_q;
endmodule

// File: rtl/pv_exp_unit.sv
// Fixed-point exponential e^x. The argument is scaled by 2^-SQ_STEPS,
// a TERMS-degree Taylor polynomial is evaluated by Horner's rule (one
// term per cycle), then the value is squared SQ_STEPS times.
// Assumes: 1 <= TERMS <= 8, SQ_STEPS >= 1; results beyond the format
// saturate to the largest positive value.
module pv_exp_unit #(
    parameter int DATA_W   = pv_nr_pkg::FX_W,
    parameter int FRAC_W   = pv_nr_pkg::FX_FRAC,
    parameter int TERMS    = 6,
    parameter int SQ_STEPS = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic signed [DATA_W-1:0] x_i,
    output logic                     done_o,
    output logic signed [DATA_W-1:0] y_o
);
    import pv_nr_pkg::*;

    localparam int K_W = $clog2(TERMS + SQ_STEPS + 1);
    localparam logic signed [DATA_W-1:0] ONE     = DATA_W'(1) <<< FRAC_W;
    localparam logic signed [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};

    exp_st_e                  st_q;
    logic [K_W-1:0]           k_q;
    logic signed [DATA_W-1:0] arg_q, acc_q;
    logic                     done_q;
    logic signed [2*DATA_W-1:0] sq_w;

    // Fixed-point product with truncation of the fractional excess.
    function automatic logic signed [DATA_W-1:0] fmul(
        input logic signed [DATA_W-1:0] a, input logic signed [DATA_W-1:0] b);
        logic signed [2*DATA_W-1:0] p;
        p = (2*DATA_W)'(a) * (2*DATA_W)'(b);
        return DATA_W'(p >>> FRAC_W);
    endfunction

    // Reciprocal of the Horner term index.
    function automatic logic signed [DATA_W-1:0] recip(input logic [K_W-1:0] k);
        case (k)
            K_W'(2): return ONE / 2;
            K_W'(3): return ONE / 3;
            K_W'(4): return ONE / 4;
            K_W'(5): return ONE / 5;
            K_W'(6): return ONE / 6;
            K_W'(7): return ONE / 7;
            K_W'(8): return ONE / 8;
            default: return ONE;
        endcase
    endfunction

    // Full-width square of the accumulator for the squaring phase.
    always_comb sq_w = ((2*DATA_W)'(acc_q) * (2*DATA_W)'(acc_q)) >>> FRAC_W;

    // Phase sequencer: Horner terms, then repeated squaring.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= E_IDLE;
            k_q    <= '0;
            arg_q  <= '0;
            acc_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                E_IDLE: if (start_i) begin
                    arg_q <= x_i >>> SQ_STEPS;
                    acc_q <= ONE;
                    k_q   <= K_W'(TERMS);
                    st_q  <= E_HORN;
                end
                E_HORN: begin
                    acc_q <= ONE + fmul(fmul(acc_q, arg_q), recip(k_q));
                    if (k_q == K_W'(1)) begin
                        k_q  <= K_W'(SQ_STEPS);
                        st_q <= E_SQR;
                    end else begin
                        k_q <= k_q - 1'b1;
                    end
                end
                E_SQR: begin
                    acc_q <= (sq_w > (2*DATA_W)'(MAX_POS)) ? MAX_POS : DATA_W'(sq_w);
                    k_q   <= k_q - 1'b1;
                    if (k_q == K_W'(1)) begin
                        st_q   <= E_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: st_q <= E_IDLE;
            endcase
        end
    end

    assign done_o = done_q;
    assign y_o    = acc_q;
endmodule

// File: rtl/pv_nr_solver.sv
// Newton-Raphson solver for the diode voltage of a single-diode
// photovoltaic cell, followed by panel voltage and temperature
// corrections. One divider and one exponential unit are shared by all
// steps. Assumes: start is a single-cycle pulse; Vt > 0.
module pv_nr_solver #(
    parameter int DATA_W    = pv_nr_pkg::FX_W,
    parameter int FRAC_W    = pv_nr_pkg::FX_FRAC,
    parameter int CELL_W    = 8,
    parameter int MAX_ITER  = 16,
    parameter int EXP_TERMS = 6,
    parameter int EXP_SQ    = 5,
    parameter int ITER_W    = $clog2(MAX_ITER + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic signed [DATA_W-1:0] irr_i,
    input  logic signed [DATA_W-1:0] ipv_i,
    input  logic signed [DATA_W-1:0] gain_i,
    input  logic signed [DATA_W-1:0] isat_i,
    input  logic signed [DATA_W-1:0] rpar_i,
    input  logic signed [DATA_W-1:0] rser_i,
    input  logic signed [DATA_W-1:0] vt_i,
    input  logic [CELL_W-1:0]        ncell_i,
    input  logic signed [DATA_W-1:0] tol_i,
    input  logic signed [DATA_W-1:0] tcell_i,
    input  logic signed [DATA_W-1:0] cti_i,
    input  logic signed [DATA_W-1:0] ctv_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic signed [DATA_W-1:0] vdiode_o,
    output logic signed [DATA_W-1:0] vpanel_o,
    output logic signed [DATA_W-1:0] icorr_o,
    output logic [ITER_W-1:0]        iter_o,
    output logic                     cap_hit_o
);
    import pv_nr_pkg::*;

    localparam logic signed [DATA_W-1:0] ONE     = DATA_W'(1) <<< FRAC_W;
    localparam logic signed [DATA_W-1:0] HALF    = ONE >>> 1;
    localparam logic signed [DATA_W-1:0] QCOEF   = (ONE * 9) / 4;         // 2.25
    localparam logic signed [DATA_W-1:0] SCOEF   = (ONE + 5000) / 10000;  // 1e-4
    localparam logic signed [DATA_W-1:0] TREF    = ONE * 25;

    solve_st_e                st_q;
    logic signed [DATA_W-1:0] irr_q, ipv_q, gain_q, isat_q, rpar_q, rser_q;
    logic signed [DATA_W-1:0] vt_q, tol_q, tcell_q, cti_q, ctv_q;
    logic [CELL_W-1:0]        ncell_q;
    logic signed [DATA_W-1:0] v_q, i0rp_q, kterm_q, x_q, num_q, den_q;
    logic signed [DATA_W-1:0] vpanel_q, icorr_q;
    logic [ITER_W-1:0]        iter_q;
    logic                     cap_q, done_q;

    logic                     div_start, div_done, exp_done;
    logic signed [DATA_W-1:0] div_num, div_den, div_quot, exp_y;
    logic signed [DATA_W-1:0] seed_w, s_w, a_w, delta_w, abs_w, dtemp_w, cells_w;

    // Fixed-point product with truncation of the fractional excess.
    function automatic logic signed [DATA_W-1:0] fmul(
        input logic signed [DATA_W-1:0] a, input logic signed [DATA_W-1:0] b);
        logic signed [2*DATA_W-1:0] p;
        p = (2*DATA_W)'(a) * (2*DATA_W)'(b);
        return DATA_W'(p >>> FRAC_W);
    endfunction

    // Seed polynomial, Newton terms and operand selection for the divider.
    always_comb begin
        s_w       = fmul(irr_q, SCOEF);
        seed_w    = HALF + s_w - fmul(QCOEF, fmul(s_w, s_w));
        a_w       = fmul(i0rp_q, exp_y);
        delta_w   = fmul(vt_q, div_quot);
        abs_w     = delta_w[DATA_W-1] ? -delta_w : delta_w;
        dtemp_w   = tcell_q - TREF;
        cells_w   = DATA_W'($signed({1'b0, ncell_q}));
        div_start = (st_q == S_XDIV) || (st_q == S_QDIV);
        div_num   = (st_q == S_XDIV) ? v_q  : num_q;
        div_den   = (st_q == S_XDIV) ? vt_q : den_q;
    end

    // Shared divider for V/Vt and for the Newton quotient.
    pv_fx_div #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start_i(div_start),
        .num_i(div_num), .den_i(div_den),
        .done_o(div_done), .quot_o(div_quot)
    );

    // Shared exponential unit.
    pv_exp_unit #(.DATA_W(DATA_W), .FRAC_W(FRAC_W),
                  .TERMS(EXP_TERMS), .SQ_STEPS(EXP_SQ)) u_exp (
        .clk(clk), .rst_n(rst_n), .start_i(st_q == S_EXPS),
        .x_i(x_q), .done_o(exp_done), .y_o(exp_y)
    );

    // Solve sequencer: capture, seed, iterate, correct, publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= S_IDLE;
            irr_q   <= '0; ipv_q  <= '0; gain_q <= '0; isat_q  <= '0;
            rpar_q  <= '0; rser_q <= '0; vt_q   <= '0; tol_q   <= '0;
            tcell_q <= '0; cti_q  <= '0; ctv_q  <= '0; ncell_q <= '0;
            v_q     <= '0; i0rp_q <= '0; kterm_q <= '0; x_q    <= '0;
            num_q   <= '0; den_q  <= '0; vpanel_q <= '0; icorr_q <= '0;
            iter_q  <= '0; cap_q  <= 1'b0; done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                S_IDLE: if (start_i) begin
                    irr_q   <= irr_i;  ipv_q  <= ipv_i;  gain_q <= gain_i;
                    isat_q  <= isat_i; rpar_q <= rpar_i; rser_q <= rser_i;
                    vt_q    <= vt_i;   tol_q  <= tol_i;  tcell_q <= tcell_i;
                    cti_q   <= cti_i;  ctv_q  <= ctv_i;  ncell_q <= ncell_i;
                    iter_q  <= '0;
                    cap_q   <= 1'b0;
                    st_q    <= S_PREP;
                end
                S_PREP: begin
                    i0rp_q  <= fmul(isat_q, rpar_q);
                    kterm_q <= fmul(ipv_q - fmul(gain_q, irr_q), rpar_q)
                               - fmul(isat_q, rpar_q);
                    v_q     <= seed_w;
                    st_q    <= S_XDIV;
                end
                S_XDIV:  st_q <= S_XWAIT;
                S_XWAIT: if (div_done) begin
                    x_q  <= div_quot;
                    st_q <= S_EXPS;
                end
                S_EXPS:  st_q <= S_EWAIT;
                S_EWAIT: if (exp_done) begin
                    num_q <= kterm_q + a_w + v_q;
                    den_q <= a_w + vt_q;
                    st_q  <= S_QDIV;
                end
                S_QDIV:  st_q <= S_QWAIT;
                S_QWAIT: if (div_done) begin
                    v_q    <= v_q - delta_w;
                    iter_q <= iter_q + 1'b1;
                    if (abs_w < tol_q) begin
                        st_q <= S_FIN;
                    end else if (iter_q == ITER_W'(MAX_ITER - 1)) begin
                        cap_q <= 1'b1;
                        st_q  <= S_FIN;
                    end else begin
                        st_q <= S_XDIV;
                    end
                end
                S_FIN: begin
                    vpanel_q <= DATA_W'((v_q - fmul(rser_q, ipv_q)) * cells_w)
                                + fmul(ctv_q, dtemp_w);
                    icorr_q  <= ipv_q + fmul(cti_q, dtemp_w);
                    done_q   <= 1'b1;
                    st_q     <= S_IDLE;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign busy_o    = (st_q != S_IDLE);
    assign done_o    = done_q;
    assign vdiode_o  = v_q;
    assign vpanel_o  = vpanel_q;
    assign icorr_o   = icorr_q;
    assign iter_o    = iter_q;
    assign cap_hit_o = cap_q;
endmodule

// File: rtl/pv_nr_solver_chk.sv
// Protocol and bound checks on the solver's ports.
// Assumes: attached to every pv_nr_solver instance by the bind below.
module pv_nr_solver_chk #(
    parameter int DATA_W   = 48,
    parameter int MAX_ITER = 16,
    parameter int ITER_W   = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start_i,
    input logic                     busy_o,
    input logic                     done_o,
    input logic                     cap_hit_o,
    input logic [ITER_W-1:0]        iter_o,
    input logic signed [DATA_W-1:0] vpanel_o
);
    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i)); // R2
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R3
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R3
    AST_IDLE_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !$past(busy_o)) |-> $stable(vpanel_o)); // R3
    AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        iter_o <= ITER_W'(MAX_ITER)); // R7
    AST_CAP_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cap_hit_o) |-> (iter_o == ITER_W'(MAX_ITER))); // R7
endmodule

bind pv_nr_solver pv_nr_solver_chk #(
    .DATA_W(DATA_W), .MAX_ITER(MAX_ITER), .ITER_W(ITER_W)
) u_pv_nr_solver_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .done_o(done_o), .cap_hit_o(cap_hit_o), .iter_o(iter_o), .vpanel_o(vpanel_o)
);

// File: tb/test_pv_nr_solver.sv
`timescale 1ns/1ps
// Directed bench for pv_nr_solver: one task per scenario.
module test_pv_nr_solver;
    localparam real SC = 16777216.0;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic signed [47:0] irr = '0, ipv = '0, gain = '0, isat = '0, rpar = '0;
    logic signed [47:0] rser = '0, vt = '0, tol = '0, tcell = '0, cti = '0, ctv = '0;
    logic [7:0] ncell = '0;
    logic busy, done, cap_hit;
    logic signed [47:0] vdiode, vpanel, icorr;
    logic [4:0] iter;

    int errors = 0, checks = 0;
    real qg, qi0, qrp, qrs, qvt, qcti, qctv;

    always #4 clk = ~clk;

    pv_nr_solver i_pv_nr_solver (
        .clk(clk), .rst_n(rst_n), .start_i(start), .irr_i(irr), .ipv_i(ipv),
        .gain_i(gain), .isat_i(isat), .rpar_i(rpar), .rser_i(rser), .vt_i(vt),
        .ncell_i(ncell), .tol_i(tol), .tcell_i(tcell), .cti_i(cti), .ctv_i(ctv),
        .busy_o(busy), .done_o(done), .vdiode_o(vdiode), .vpanel_o(vpanel),
        .icorr_o(icorr), .iter_o(iter), .cap_hit_o(cap_hit)
    );

    function automatic logic signed [47:0] to_fx(real x);
        return 48'(longint'(x * SC));
    endfunction

    function automatic real fr(logic signed [47:0] v);
        return real'(longint'(v)) / SC;
    endfunction

    task automatic chk(bit ok, string req, string what, real act, real expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%f expected=%f", req, what, act, expv);
        end
    endtask

    function automatic real seed(real sr);
        real s;
        s = 0.1 * sr / 1000.0;
        return 0.5 + s - 2.25 * s * s;
    endfunction

    // Real-valued Newton iteration on the quantized parameters.
    function automatic real model_vd(real sr, real ip, real tl, int cap, output int its);
        real v, e, d;
        v = seed(sr);
        its = 0;
        for (int k = 1; k <= cap; k++) begin
            e = $exp(v / qvt);
            d = qvt * (ip * qrp - qg * sr * qrp + qi0 * qrp * e - qi0 * qrp + v)
                / (qi0 * qrp * e + qvt);
            v = v - d;
            its = k;
            if ((d < 0.0 ? -d : d) < tl) break;
        end
        return v;
    endfunction

    task automatic launch(real sr, real ip, real tc, real tl);
        @(negedge clk);
        irr = to_fx(sr); ipv = to_fx(ip); tcell = to_fx(tc); tol = to_fx(tl);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done, "R3", "done seen before timeout", real'(done), 1.0);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !cap_hit && iter == 0, "R1", "control outputs zero",
            real'(busy) + real'(done) + real'(iter), 0.0);
        chk(vdiode == 0 && vpanel == 0 && icorr == 0, "R1", "data outputs zero",
            fr(vpanel), 0.0);
    endtask

    task automatic t_first_step();
        real ev;
        int its;
        launch(1000.0, 0.0, 25.0, 1.0);
        wait_done();
        ev = model_vd(1000.0, 0.0, 1.0, 16, its);
        chk(iter == 1, "R4", "single step count", real'(iter), 1.0);
        chk((fr(vdiode) - ev) < 1e-3 && (ev - fr(vdiode)) < 1e-3, "R4",
            "seed minus one step", fr(vdiode), ev);
    endtask

    task automatic t_converge(real sr, real ip);
        real ev, evp;
        int its;
        launch(sr, ip, 25.0, 1e-4);
        wait_done();
        ev  = model_vd(sr, ip, 1e-4, 16, its);
        evp = 36.0 * (fr(vdiode) - qrs * fr(to_fx(ip)));
        chk((fr(vdiode) - ev) < 1e-3 && (ev - fr(vdiode)) < 1e-3, "R5",
            "converged diode voltage", fr(vdiode), ev);
        chk(iter >= 1 && iter <= 5 && !cap_hit, "R6", "step count 1..5",
            real'(iter), 5.0);
        chk((fr(vpanel) - evp) < 1e-3 && (evp - fr(vpanel)) < 1e-3, "R8",
            "panel voltage at 25 C", fr(vpanel), evp);
    endtask

    task automatic t_cap();
        real ev;
        int its;
        launch(800.0, 2.0, 25.0, 0.0);
        wait_done();
        ev = model_vd(800.0, 2.0, 1e-9, 16, its);
        chk(iter == 16 && cap_hit, "R7", "cap reached with zero tolerance",
            real'(iter), 16.0);
        chk((fr(vdiode) - ev) < 1e-3 && (ev - fr(vdiode)) < 1e-3, "R7",
            "voltage after cap", fr(vdiode), ev);
    endtask

    task automatic t_temp();
        real evp, eic;
        launch(1000.0, 4.0, 50.0, 1e-4);
        wait_done();
        evp = 36.0 * (fr(vdiode) - qrs * 4.0) + qctv * 25.0;
        eic = 4.0 + qcti * 25.0;
        chk(!cap_hit, "R7", "converged before cap", real'(cap_hit), 0.0);
        chk((fr(vpanel) - evp) < 1e-3 && (evp - fr(vpanel)) < 1e-3, "R8",
            "panel voltage at 50 C", fr(vpanel), evp);
        chk((fr(icorr) - eic) < 1e-4 && (eic - fr(icorr)) < 1e-4, "R9",
            "corrected current", fr(icorr), eic);
    endtask

    task automatic t_busy_ignore();
        real ev;
        int its;
        launch(1000.0, 0.0, 25.0, 1e-4);
        repeat (30) @(negedge clk);
        irr = to_fx(400.0); ipv = to_fx(2.0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R2", "busy kept after ignored start", real'(busy), 1.0);
        wait_done();
        chk(!busy, "R3", "busy low at done", real'(busy), 0.0);
        ev = model_vd(1000.0, 0.0, 1e-4, 16, its);
        chk((fr(vdiode) - ev) < 1e-3 && (ev - fr(vdiode)) < 1e-3, "R2",
            "result of first inputs", fr(vdiode), ev);
        @(negedge clk);
        chk(!done && !busy, "R3", "done lasts one cycle", real'(done), 0.0);
    endtask

    task automatic t_back_to_back();
        real eva, evb;
        int its;
        launch(1000.0, 0.0, 25.0, 1e-4);
        wait_done();
        eva = model_vd(1000.0, 0.0, 1e-4, 16, its);
        chk((fr(vdiode) - eva) < 1e-3 && (eva - fr(vdiode)) < 1e-3, "R10",
            "first result at done", fr(vdiode), eva);
        irr = to_fx(600.0); ipv = to_fx(1.0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R10", "start in done cycle accepted", real'(busy), 1.0);
        wait_done();
        evb = model_vd(600.0, 1.0, 1e-4, 16, its);
        chk((fr(vdiode) - evb) < 1e-3 && (evb - fr(vdiode)) < 1e-3, "R10",
            "second result uses new inputs", fr(vdiode), evb);
    endtask

    initial begin
        #(8.0 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        gain  = to_fx(0.008);  isat = to_fx(7.7e-5); rpar = to_fx(100.0);
        rser  = to_fx(0.005);  vt   = to_fx(0.05);   ncell = 8'd36;
        cti   = to_fx(0.003);  ctv  = to_fx(-0.08);  tcell = to_fx(25.0);
        qg  = fr(gain); qi0 = fr(isat); qrp = fr(rpar); qrs = fr(rser);
        qvt = fr(vt);   qcti = fr(cti); qctv = fr(ctv);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_step();
        t_converge(1000.0, 0.0);
        t_converge(800.0, 2.0);
        t_converge(600.0, 1.0);
        t_converge(400.0, 2.0);
        t_converge(1000.0, 4.0);
        t_cap();
        t_temp();
        t_busy_ignore();
        t_back_to_back();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule